// File: doc/BRIEF.md
# Serial DAC Frame Writer

This block drives a 14-bit serial-input DAC from a parallel host port. The host offers a code with a valid/ready handshake; the writer turns it into a 16-clock frame on a three-wire link (active-low select, serial clock, serial data). An optional active-low load strobe follows each frame. The frame has two leading padding bits and then the 14 code bits, most significant first. The link clock idles low and the data changes on falling edges, so the slave samples stable data on each rising edge. This matches SPI mode 0. Select stays low across both 8-bit halves of the frame. Its rising edge makes the slave take the word.

Each word carries two per-transfer options, sampled when the word is accepted. One bit-reverses a code that the host supplies least-significant-bit first. The other requests the load strobe after the frame. All link timing is set by parameters counted in system clock cycles: clock half period, select setup, select hold, strobe delay, strobe width and select idle time. A second parameter gives the system clock period in picoseconds, and assertions use it to hold each measured interval against its minimum time on the link.

Top module: `dac_frame_writer`

## Requirements
- R1: While reset is asserted and after it is released, select and the load strobe are high, the serial clock is low and `in_ready` is 1.
- R2: Each frame has exactly 16 rising serial-clock edges while select is low. The bits sampled on them are two padding bits, driven as 0, followed by `in_code[13]` down to `in_code[0]`.
- R3: When `in_lsb_first` is 1 at acceptance, the code is bit-reversed, so the 14 data bits arrive as `in_code[0]` first through `in_code[13]` last.
- R4: Serial data never changes in the cycle in which the serial clock rises.
- R5: Inside a frame, each high phase and each low phase between two rising edges lasts exactly HALF_CYC cycles. The serial clock is low whenever select is high.
- R6: Select falls exactly CS_SETUP_CYC + HALF_CYC cycles before the first rising edge. It rises exactly HALF_CYC + CS_HOLD_CYC cycles after the last rising edge.
- R7: When `in_use_strobe` is 1 at acceptance, the load strobe falls exactly LD_DELAY_CYC cycles after select rises and stays low for LD_PULSE_CYC cycles. When it is 0, the strobe stays high for that frame.
- R8: `in_ready` is 0 from the cycle after acceptance until CS_IDLE_CYC cycles after select rises, or after the strobe ends when a strobe was requested. Select therefore stays high for at least CS_IDLE_CYC + 1 cycles between frames.
- R9: A word is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_valid`, `in_code` and the option bits have no effect while `in_ready` is 0.
- R10: Measured in time, the clock phases are at least 20 ns, select setup is at least 15 ns, select hold is at least 20 ns, data setup is at least 15 ns, and strobe delay, strobe width and select idle time are each at least 30 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host offers a code |
| in_ready | output | 1 | Writer can accept a code |
| in_code | input | CODE_W | Code to send |
| in_lsb_first | input | 1 | Code is given least significant bit first |
| in_use_strobe | input | 1 | Issue a load strobe after this frame |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdo | output | 1 | Serial data to the DAC |
| dac_ld_n | output | 1 | Active-low load strobe |

## Verification
Every output comes straight from a register. Select falls on the edge that accepts a word, and `in_ready` is already low at the next falling system-clock edge. Each later event sits a fixed number of cycles after the event before it: the first rising edge CS_SETUP_CYC + HALF_CYC after select falls, every phase HALF_CYC long, select rising HALF_CYC + CS_HOLD_CYC after the last rising edge, the strobe falling LD_DELAY_CYC after that and lasting LD_PULSE_CYC, and ready returning CS_IDLE_CYC after the strobe or after select. The monitor samples the pins on falling system-clock edges, counts the samples between transitions and compares them with these exact counts. It rebuilds each frame from the rising edges and checks it against the word the driver queued.

// File: rtl/dfw_pkg.sv
package dfw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_LDWAIT,
        ST_LDPULSE,
        ST_GAP
    } dfw_state_e;

    // Minimum link intervals in picoseconds
    localparam int MIN_PHASE_PS      = 20000;
    localparam int MIN_CS_SETUP_PS   = 15000;
    localparam int MIN_CS_HOLD_PS    = 20000;
    localparam int MIN_DATA_SETUP_PS = 15000;
    localparam int MIN_LOAD_PS       = 30000;
    localparam int MIN_CS_IDLE_PS    = 30000;

    typedef logic [15:0] run_t;

    function automatic int dfw_max6(int a, int b, int c, int d, int e, int f);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        if (f > m) m = f;
        return m;
    endfunction

    function automatic run_t run_inc(run_t v);
        return (v == '1) ? v : v + run_t'(1);
    endfunction

endpackage

// File: rtl/dfw_bitorder.sv
module dfw_bitorder #(
    parameter int W = 14
) (
    input  logic         reverse,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = reverse ? din[W-1-i] : din[i];
    end
endmodule

// File: rtl/dfw_shifter.sv
module dfw_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load) begin
            sh_d = load_val;
        end else if (shift) begin
            sh_d = {sh_q[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign msb = sh_q[W-1];
endmodule

// File: rtl/dac_frame_writer.sv
module dac_frame_writer
    import dfw_pkg::*;
#(
    parameter int CODE_W       = 14,
    parameter int PAD_W        = 2,
    parameter int HALF_CYC     = 5,
    parameter int CS_SETUP_CYC = 4,
    parameter int CS_HOLD_CYC  = 5,
    parameter int LD_DELAY_CYC = 8,
    parameter int LD_PULSE_CYC = 8,
    parameter int CS_IDLE_CYC  = 8,
    parameter int SYS_PS       = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [CODE_W-1:0] in_code,
    input  logic              in_lsb_first,
    input  logic              in_use_strobe,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdo,
    output logic              dac_ld_n
);
    localparam int FRAME_W = PAD_W + CODE_W;
    localparam int MAX_CYC = dfw_max6(CS_SETUP_CYC + HALF_CYC, HALF_CYC, CS_HOLD_CYC,
                                      LD_DELAY_CYC, LD_PULSE_CYC, CS_IDLE_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int BIT_W   = $clog2(FRAME_W);

    typedef struct packed {
        dfw_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bits;
        logic             cs_n;
        logic             sclk;
        logic             ld_n;
        logic             strobe;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [CODE_W-1:0]  code_ordered;
    logic [FRAME_W-1:0] frame_word;
    logic               load_frame;
    logic               shift_frame;

    dfw_bitorder #(.W(CODE_W)) i_order (
        .reverse (in_lsb_first),
        .din     (in_code),
        .dout    (code_ordered)
    );

    assign frame_word = {{PAD_W{1'b0}}, code_ordered};

    dfw_shifter #(.W(FRAME_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_frame),
        .load_val (frame_word),
        .shift    (shift_frame),
        .msb      (dac_sdo)
    );

    always_comb begin
        r_d         = r_q;
        load_frame  = 1'b0;
        shift_frame = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (in_valid) begin
                    load_frame = 1'b1;
                    r_d.st     = ST_LOW;
                    r_d.cnt    = CNT_W'(CS_SETUP_CYC + HALF_CYC - 1);
                    r_d.bits   = BIT_W'(FRAME_W - 1);
                    r_d.cs_n   = 1'b0;
                    r_d.strobe = in_use_strobe;
                end
            end
            ST_LOW: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_HIGH;
                    r_d.sclk = 1'b1;
                    r_d.cnt  = CNT_W'(HALF_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == '0) begin
                    r_d.sclk = 1'b0;
                    if (r_q.bits == '0) begin
                        r_d.st  = ST_HOLD;
                        r_d.cnt = CNT_W'(CS_HOLD_CYC - 1);
                    end else begin
                        shift_frame = 1'b1;
                        r_d.st      = ST_LOW;
                        r_d.bits    = r_q.bits - BIT_W'(1);
                        r_d.cnt     = CNT_W'(HALF_CYC - 1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.cs_n = 1'b1;
                    if (r_q.strobe) begin
                        r_d.st  = ST_LDWAIT;
                        r_d.cnt = CNT_W'(LD_DELAY_CYC - 1);
                    end else begin
                        r_d.st  = ST_GAP;
                        r_d.cnt = CNT_W'(CS_IDLE_CYC - 1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_LDWAIT: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_LDPULSE;
                    r_d.ld_n = 1'b0;
                    r_d.cnt  = CNT_W'(LD_PULSE_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_LDPULSE: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_GAP;
                    r_d.ld_n = 1'b1;
                    r_d.cnt  = CNT_W'(CS_IDLE_CYC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, bits: '0, cs_n: 1'b1,
                     sclk: 1'b0, ld_n: 1'b1, strobe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready = (r_q.st == ST_IDLE);
    assign dac_cs_n = r_q.cs_n;
    assign dac_sclk = r_q.sclk;
    assign dac_ld_n = r_q.ld_n;

    // Interval meters on the pins, used only by the timing assertions
    run_t hi_run_q, lo_run_q, cs_lo_run_q, cs_hi_run_q, ld_lo_run_q, since_rise_q;
    logic sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q     <= '1;
            lo_run_q     <= '1;
            cs_lo_run_q  <= '1;
            cs_hi_run_q  <= '1;
            ld_lo_run_q  <= '1;
            since_rise_q <= '1;
            sclk_prev_q  <= 1'b0;
        end else begin
            hi_run_q     <= dac_sclk  ? run_inc(hi_run_q)    : '0;
            lo_run_q     <= !dac_sclk ? run_inc(lo_run_q)    : '0;
            cs_lo_run_q  <= !dac_cs_n ? run_inc(cs_lo_run_q) : '0;
            cs_hi_run_q  <= dac_cs_n  ? run_inc(cs_hi_run_q) : '0;
            ld_lo_run_q  <= !dac_ld_n ? run_inc(ld_lo_run_q) : '0;
            since_rise_q <= (dac_sclk && !sclk_prev_q) ? run_t'(1) : run_inc(since_rise_q);
            sclk_prev_q  <= dac_sclk;
        end
    end

    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n || !dac_ld_n) |-> !in_ready);

    p_sdo_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable(dac_sdo));

    p_strobe_cs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_ld_n |-> dac_cs_n);

    p_sclk_high_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_sclk) |-> (int'(hi_run_q) * SYS_PS >= MIN_PHASE_PS));

    p_sclk_low_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> (int'(lo_run_q) * SYS_PS >= MIN_PHASE_PS) &&
                            (int'(lo_run_q) * SYS_PS >= MIN_DATA_SETUP_PS));

    p_cs_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> (int'(cs_lo_run_q) * SYS_PS >= MIN_CS_SETUP_PS));

    p_cs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_cs_n) |-> (int'(since_rise_q) * SYS_PS >= MIN_CS_HOLD_PS));

    p_strobe_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ld_n) |-> (int'(cs_hi_run_q) * SYS_PS >= MIN_LOAD_PS));

    p_strobe_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_ld_n) |-> (int'(ld_lo_run_q) * SYS_PS >= MIN_LOAD_PS));

    p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_cs_n) |-> (int'(cs_hi_run_q) * SYS_PS >= MIN_CS_IDLE_PS));

endmodule

// File: tb/test_dac_frame_writer.sv
module test_dac_frame_writer;
    localparam int CODE_W   = 14;
    localparam int FRAME_W  = 16;
    localparam int HALF     = 5;
    localparam int SETUP    = 4;
    localparam int HOLD     = 5;
    localparam int LDDEL    = 8;
    localparam int LDPUL    = 8;
    localparam int IDLE     = 8;
    localparam int CLK_NS   = 4;
    localparam int WATCHDOG = 50000;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ready, in_lsb_first, in_use_strobe;
    logic [CODE_W-1:0] in_code;
    logic dac_cs_n, dac_sclk, dac_sdo, dac_ld_n;

    always #2 clk = ~clk;

    dac_frame_writer #(
        .CODE_W(CODE_W), .PAD_W(FRAME_W - CODE_W), .HALF_CYC(HALF),
        .CS_SETUP_CYC(SETUP), .CS_HOLD_CYC(HOLD), .LD_DELAY_CYC(LDDEL),
        .LD_PULSE_CYC(LDPUL), .CS_IDLE_CYC(IDLE), .SYS_PS(CLK_NS * 1000)
    ) i_dac_frame_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_code(in_code), .in_lsb_first(in_lsb_first), .in_use_strobe(in_use_strobe),
        .dac_cs_n(dac_cs_n), .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .dac_ld_n(dac_ld_n)
    );

    typedef struct {
        logic [FRAME_W-1:0] bits;
        bit                 strobe;
        string              req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [CODE_W-1:0] flip(logic [CODE_W-1:0] v);
        logic [CODE_W-1:0] r;
        for (int i = 0; i < CODE_W; i++) r[i] = v[CODE_W-1-i];
        return r;
    endfunction

    function automatic int gap_cycles(bit strobe);
        return IDLE + (strobe ? LDDEL + LDPUL : 0);
    endfunction

    // Driver: offers one word, queues the frame expected on the pins
    task automatic send(logic [CODE_W-1:0] code, bit lsb, bit strobe, bit poke);
        exp_t e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_code       = code;
        in_lsb_first  = lsb;
        in_use_strobe = strobe;
        in_valid      = 1'b1;
        e.bits   = {2'b00, (lsb ? flip(code) : code)};
        e.strobe = strobe;
        e.req    = lsb ? "R3" : "R2";
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!in_ready, "R9", "ready after acceptance", int'(in_ready), 0);
        if (poke) begin
            // R9: inputs disturbed while busy must not alter the frame
            in_code       = ~code;
            in_lsb_first  = ~lsb;
            in_use_strobe = ~strobe;
            in_valid      = 1'b1;
            repeat (20) @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor state
    bit   prev_cs, prev_sclk, prev_ld, prev_ready, prev_sdo;
    int   phase_cnt, since_rise, since_cs, ld_lo, nrise;
    bit   pending_strobe, ld_seen, seen_frame;
    logic [FRAME_W-1:0] cap;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1; prev_sclk = 0; prev_ld = 1; prev_ready = 1; prev_sdo = 0;
            phase_cnt = 0; since_rise = 0; since_cs = 0; ld_lo = 0; nrise = 0;
            pending_strobe = 0; ld_seen = 0; seen_frame = 0; cap = '0;
        end else begin
            if (prev_cs && !dac_cs_n) begin
                if (seen_frame) begin
                    chk(since_cs >= gap_cycles(pending_strobe) + 1, "R8", "select high cycles",
                        since_cs, gap_cycles(pending_strobe) + 1);
                    chk(since_cs * CLK_NS >= 30, "R10", "select idle ns", since_cs * CLK_NS, 30);
                    chk(ld_seen == pending_strobe, "R7", "strobe presence",
                        int'(ld_seen), int'(pending_strobe));
                end
                chk(!in_ready, "R8", "ready while select low", int'(in_ready), 0);
                chk(!dac_sclk, "R5", "clock low at select fall", int'(dac_sclk), 0);
                phase_cnt = 0; nrise = 0; cap = '0;
            end else if (dac_sclk != prev_sclk) begin
                if (dac_sclk) begin
                    if (nrise == 0) begin
                        chk(phase_cnt == SETUP + HALF, "R6", "select fall to first rise",
                            phase_cnt, SETUP + HALF);
                        chk(phase_cnt * CLK_NS >= 15, "R10", "select setup ns",
                            phase_cnt * CLK_NS, 15);
                    end else begin
                        chk(phase_cnt == HALF, "R5", "low phase", phase_cnt, HALF);
                    end
                    chk(dac_sdo == prev_sdo, "R4", "data steady at rise", int'(dac_sdo), int'(prev_sdo));
                    cap = {cap[FRAME_W-2:0], dac_sdo};
                    nrise++;
                    since_rise = 0;
                end else begin
                    chk(phase_cnt == HALF, "R5", "high phase", phase_cnt, HALF);
                    chk(phase_cnt * CLK_NS >= 20, "R10", "high phase ns", phase_cnt * CLK_NS, 20);
                end
                phase_cnt = 0;
            end
            if (!prev_cs && dac_cs_n) begin
                exp_t e;
                chk(since_rise == HALF + HOLD, "R6", "last rise to select rise", since_rise, HALF + HOLD);
                chk(nrise == FRAME_W, "R2", "rising edges in frame", nrise, FRAME_W);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected frame", int'(cap), 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(cap == e.bits, e.req, "frame bits", int'(cap), int'(e.bits));
                    pending_strobe = e.strobe;
                end
                since_cs = 0; ld_seen = 0; seen_frame = 1;
            end
            if (prev_ld && !dac_ld_n) begin
                chk(pending_strobe && since_cs == LDDEL, "R7", "strobe delay", since_cs, LDDEL);
                chk(!in_ready, "R8", "ready during strobe", int'(in_ready), 0);
                ld_lo = 0; ld_seen = 1;
            end
            if (!prev_ld && dac_ld_n) begin
                chk(ld_lo == LDPUL, "R7", "strobe width", ld_lo, LDPUL);
                chk(ld_lo * CLK_NS >= 30, "R10", "strobe width ns", ld_lo * CLK_NS, 30);
            end
            if (!prev_ready && in_ready && seen_frame) begin
                chk(since_cs == gap_cycles(pending_strobe), "R8", "ready return",
                    since_cs, gap_cycles(pending_strobe));
            end
            phase_cnt++; since_rise++; since_cs++; ld_lo++;
            prev_cs = dac_cs_n; prev_sclk = dac_sclk; prev_ld = dac_ld_n;
            prev_ready = in_ready; prev_sdo = dac_sdo;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_code = '0;
        in_lsb_first = 1'b0; in_use_strobe = 1'b0;
        repeat (3) @(negedge clk);
        chk(dac_cs_n == 1'b1, "R1", "select in reset", int'(dac_cs_n), 1);
        chk(dac_sclk == 1'b0, "R1", "clock in reset", int'(dac_sclk), 0);
        chk(dac_ld_n == 1'b1, "R1", "strobe in reset", int'(dac_ld_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
        chk(dac_cs_n == 1'b1, "R1", "select after reset", int'(dac_cs_n), 1);

        send(14'h3FFF, 1'b0, 1'b0, 1'b0);
        send(14'h0000, 1'b0, 1'b0, 1'b0);
        send(14'h2000, 1'b0, 1'b1, 1'b0);
        send(14'h1555, 1'b1, 1'b0, 1'b0);
        send(14'h0001, 1'b1, 1'b1, 1'b1);
        send(14'h2AAA, 1'b0, 1'b0, 1'b1);
        send(14'h0F0F, 1'b1, 1'b1, 1'b0);

        @(negedge clk);
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(ld_seen == pending_strobe, "R7", "final strobe presence",
            int'(ld_seen), int'(pending_strobe));
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule